// File: doc/BRIEF.md
# I2C Slave Masked Address Recognizer

This block runs the address phase of an I2C slave. It watches the two bus lines through a synchroniser. It detects START, repeated START and STOP, and shifts in the first byte after a start, most significant bit first, on each rising SCL edge. The top seven bits of that byte are compared with a programmable own address. A per-bit mask chooses which bits take part in the compare. The eighth bit is the read/write direction.

If the compare fails, the block does nothing on the bus, so the ninth clock reads as NACK. It then stays idle until the next START. If the compare passes, the block raises a match flag and reports the direction. It also pulls SCL low once the master has driven SCL low after the eighth bit, and keeps it low until the host issues an acknowledge or not-acknowledge command. It then drives the acknowledge bit for the ninth clock. An optional general-call acceptance adds address 0 with a write direction to the accepted set, and reports it on its own flag.

Both bus outputs are open-drain pull-down requests. The surrounding pad logic turns a 1 into a low level on the wire. Data bytes after the address are handled elsewhere.

Top module: `i2c_addr_match`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new address phase from any state. A repeated START in the middle of an address discards the bits already shifted in, and the following eight bits form the address byte.
- R2: Address bits are sampled on SCL rising edges, most significant bit first. The eighth bit is the direction (1 = read). It appears on rw_o while match_o is high and is stable for that whole time.
- R3: The masked compare accepts the byte when, for every mask bit that is 1, the received address bit equals the own-address bit; a mask bit of 0 makes that bit don't-care. With mask 0x00 every address is accepted. With mask 0x7F only the exact address is accepted. With mask 0x70 any address whose upper three bits equal those of the own address is accepted.
- R4: On a rejected address, scl_low_o and sda_low_o stay 0 through the ninth clock, so it reads as NACK. The block then ignores all bus activity until the next START, even bytes that would match.
- R5: On an accepted address, match_o rises and scl_low_o is asserted after the SCL falling edge that ends the eighth bit. While match_o is high, SCL stays held low and sda_low_o stays 0, however long the host waits.
- R6: While match_o is high, a pulse on ack_cmd_i makes sda_low_o 1 (ACK) for the ninth bit. A pulse on nack_cmd_i alone leaves sda_low_o 0 (NACK). If both are high in the same cycle, ACK wins. The command clears match_o on the next cycle.
- R7: sda_low_o changes only while SCL is low. SCL is released SETUP_CYC cycles after the command. The ACK level is held through exactly one SCL high period and is removed after the SCL falling edge that ends the ninth bit.
- R8: With gc_en_i = 1, the byte 0x00 (address 0, write) is accepted whatever the own address and mask, and gc_o is 1 together with match_o. With gc_en_i = 0, address 0 is accepted only through the masked compare and gc_o stays 0. The byte 0x01 (address 0, read) is never accepted through the general-call path.
- R9: A STOP (SDA rising while SCL is high) during an address phase abandons it. On the next cycle both pull-downs and match_o are 0.
- R10: During and just after reset, scl_low_o, sda_low_o, match_o and gc_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| scl_low_o | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_low_o | output | 1 | 1 = pull SDA low (acknowledge) |
| own_addr_i | input | ADDR_W | Own slave address |
| addr_mask_i | input | ADDR_W | Compare mask, 1 = bit compared |
| gc_en_i | input | 1 | Accept general call (byte 0x00) |
| ack_cmd_i | input | 1 | Host command: acknowledge the address |
| nack_cmd_i | input | 1 | Host command: do not acknowledge |
| match_o | output | 1 | Address accepted, waiting for host command |
| gc_o | output | 1 | Accepted byte is a general call |
| rw_o | output | 1 | Direction bit of the accepted byte |

## Verification
All 256 first bytes are driven under mask 0x7F, all 256 under mask 0x70, and every fourth byte under mask 0x00. Mask 0x7F separates the own address from every neighbour that differs in one bit. Mask 0x70 shows that only the upper three bits decide. Mask 0x00 shows that no bit is still compared. Bytes 0x00 and 0x01 are tried with the general-call enable on and off, and with an own address of zero, to separate acceptance through the general-call path from acceptance through the compare. Separate runs cover:
- a repeated START after a partial matching and a partial non-matching prefix;
- a STOP in the middle of the address;
- a long host delay while SCL is held;
- simultaneous ACK and NACK commands;
- a matching byte clocked after a NACK without a new START.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_SETUP,
    ST_BIT9
  } am_state_e;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges only count while SCL stays high across both samples
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic [ADDR_W:0]   byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              gc_en_i,
  output logic              accept_o,
  output logic              gc_hit_o
);
  logic [ADDR_W-1:0] bit_ok;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_ok[i] = ~mask_i[i] | (byte_i[i+1] ~^ own_addr_i[i]);
  end

  // general call: all-zero address with write direction
  assign gc_hit_o = gc_en_i & (byte_i == '0);
  assign accept_o = (&bit_ok) | gc_hit_o;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int unsigned ADDR_W      = i2c_am_pkg::ADDR_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETUP_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] addr_mask_i,
  input  logic              gc_en_i,
  input  logic              ack_cmd_i,
  input  logic              nack_cmd_i,
  output logic              match_o,
  output logic              gc_o,
  output logic              rw_o
);
  localparam int unsigned NBITS = ADDR_W + 1;
  localparam int unsigned CNT_W = $clog2(NBITS + 1);
  localparam int unsigned SU_W  = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(NBITS);
  localparam logic [SU_W-1:0]  SU_LAST  = SU_W'(SETUP_CYC - 1);

  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       accept, gc_hit;

  am_state_e        state_q;
  logic [NBITS-1:0] shreg_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [SU_W-1:0]  su_cnt_q;
  logic             saw_rise_q;
  logic             match_q, gc_q, rw_q, scl_low_q, sda_low_q;

  i2c_am_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_am_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_am_cmp #(
    .ADDR_W(ADDR_W)
  ) u_cmp (
    .byte_i    (shreg_q),
    .own_addr_i(own_addr_i),
    .mask_i    (addr_mask_i),
    .gc_en_i   (gc_en_i),
    .accept_o  (accept),
    .gc_hit_o  (gc_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      shreg_q    <= '0;
      bit_cnt_q  <= '0;
      su_cnt_q   <= '0;
      saw_rise_q <= 1'b0;
      match_q    <= 1'b0;
      gc_q       <= 1'b0;
      rw_q       <= 1'b0;
      scl_low_q  <= 1'b0;
      sda_low_q  <= 1'b0;
    end else if (start_det || stop_det) begin
      state_q   <= start_det ? ST_ADDR : ST_IDLE;
      bit_cnt_q <= '0;
      match_q   <= 1'b0;
      gc_q      <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && bit_cnt_q != LAST_BIT) begin
            shreg_q   <= {shreg_q[NBITS-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
            if (accept) begin
              state_q   <= ST_HOLD;
              match_q   <= 1'b1;
              gc_q      <= gc_hit;
              rw_q      <= shreg_q[0];
              scl_low_q <= 1'b1;
            end else begin
              // rejected: stay off the bus until the next START
              state_q <= ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (ack_cmd_i || nack_cmd_i) begin
            sda_low_q <= ack_cmd_i;
            match_q   <= 1'b0;
            gc_q      <= 1'b0;
            su_cnt_q  <= '0;
            state_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (su_cnt_q == SU_LAST) begin
            scl_low_q  <= 1'b0;
            saw_rise_q <= 1'b0;
            state_q    <= ST_BIT9;
          end else begin
            su_cnt_q <= su_cnt_q + 1'b1;
          end
        end
        ST_BIT9: begin
          if (scl_rise) saw_rise_q <= 1'b1;
          if (scl_fall && saw_rise_q) begin
            sda_low_q <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;
  assign match_o   = match_q;
  assign gc_o      = gc_q;
  assign rw_o      = rw_q;
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic gc_en_i,
  input logic ack_cmd_i,
  input logic nack_cmd_i,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic match_o,
  input logic gc_o,
  input logic rw_o,
  input logic start_det_i,
  input logic stop_det_i
);
  p_start_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i |=> (!match_o && !scl_low_o && !sda_low_o));

  p_rw_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(match_o)) |-> $stable(rw_o));

  p_match_stretch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (scl_low_o && !sda_low_o));

  p_ack_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && ack_cmd_i && !start_det_i && !stop_det_i) |=> (sda_low_o && !match_o));

  p_nack_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && nack_cmd_i && !ack_cmd_i && !start_det_i && !stop_det_i)
      |=> (!sda_low_o && !match_o));

  p_sda_scl_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_o) |-> !scl_i);

  p_gc_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_o |-> (gc_en_i && match_o));

  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> (!scl_low_o && !sda_low_o && !match_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_idle_r10: assert (!match_o && !gc_o);
    end
  end
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .gc_en_i    (gc_en_i),
  .ack_cmd_i  (ack_cmd_i),
  .nack_cmd_i (nack_cmd_i),
  .scl_low_o  (scl_low_o),
  .sda_low_o  (sda_low_o),
  .match_o    (match_o),
  .gc_o       (gc_o),
  .rw_o       (rw_o),
  .start_det_i(start_det),
  .stop_det_i (stop_det)
);

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
  localparam int H = 6;
  localparam int WATCHDOG = 195000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [6:0] own_addr = 7'h5A;
  logic [6:0] mask = 7'h7F;
  logic       gc_en = 1'b0;
  logic       ack_cmd = 1'b0;
  logic       nack_cmd = 1'b0;
  logic       scl_low, sda_low, match, gc, rw;
  logic       scl_w, sda_w;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign scl_w = m_scl & ~scl_low;
  assign sda_w = m_sda & ~sda_low;

  i2c_addr_match dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_w),
    .sda_i      (sda_w),
    .scl_low_o  (scl_low),
    .sda_low_o  (sda_low),
    .own_addr_i (own_addr),
    .addr_mask_i(mask),
    .gc_en_i    (gc_en),
    .ack_cmd_i  (ack_cmd),
    .nack_cmd_i (nack_cmd),
    .match_o    (match),
    .gc_o       (gc),
    .rw_o       (rw)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_accept(input logic [7:0] b, input logic [6:0] a,
                                    input logic [6:0] m, input bit g);
    return (((b[7:1] ^ a) & m) == 7'h0) || (g && b == 8'h00);
  endfunction

  task automatic bus_start();
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    wt(2); m_sda = 1'b1; wt(2);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(2); m_sda = 1'b0; wt(2);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic clk_bit(input logic b);
    wt(2); m_sda = b; wt(H - 2);
    m_scl = 1'b1;
    while (!scl_w) wt(1);
    wt(H);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    wt(2); m_sda = 1'b1; wt(H - 2);
  endtask

  // ninth clock; returns SDA level seen while SCL is high
  task automatic ninth(output logic seen);
    m_scl = 1'b1;
    while (!scl_w) wt(1);
    wt(3);
    seen = sda_w;
    wt(H - 3);
    m_scl = 1'b0;
    wt(H);
  endtask

  task automatic cmd(input bit a, input bit n);
    ack_cmd = a; nack_cmd = n;
    wt(1);
    ack_cmd = 1'b0; nack_cmd = 1'b0;
  endtask

  task automatic txn(input logic [7:0] b, input int hold, input bit both);
    logic acc, egc, seen, do_ack;
    acc    = exp_accept(b, own_addr, mask, gc_en);
    egc    = gc_en && (b == 8'h00);
    do_ack = both || (b[2] == 1'b0);
    bus_start();
    send_byte(b);
    chk("R3 match", match, acc);
    if (acc) begin
      chk("R2 rw", rw, b[0]);
      chk("R8 gc flag", gc, egc);
      chk("R5 stretch", scl_w, 0);
      if (hold > 0) begin
        wt(hold);
        chk("R5 stretch held", scl_w, 0);
        chk("R5 match held", match, 1);
      end
      cmd(do_ack, both || !do_ack);
      chk("R6 match cleared", match, 0);
    end else begin
      chk("R4 no stretch", scl_low, 0);
    end
    ninth(seen);
    chk(acc ? "R6 ack level" : "R4 auto nack", seen, (acc && do_ack) ? 0 : 1);
    chk("R7 sda released", sda_w, 1);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic seen;
    wt(4);
    chk("R10 reset scl", scl_low, 0);
    chk("R10 reset sda", sda_low, 0);
    chk("R10 reset match", match, 0);
    chk("R10 reset gc", gc, 0);
    rst_n = 1'b1;
    wt(4);
    chk("R10 after reset scl", scl_low, 0);
    chk("R10 after reset match", match, 0);

    // exact compare
    own_addr = 7'h5A; mask = 7'h7F; gc_en = 1'b0;
    for (int b = 0; b < 256; b++) txn(8'(b), 0, 1'b0);
    // upper three bits only
    mask = 7'h70;
    for (int b = 0; b < 256; b++) txn(8'(b), 0, 1'b0);
    // nothing compared
    mask = 7'h00;
    for (int b = 0; b < 256; b += 4) txn(8'(b), 0, 1'b0);

    // general call on and off
    mask = 7'h7F;
    gc_en = 1'b1; txn(8'h00, 0, 1'b0); txn(8'h01, 0, 1'b0);  // R8
    gc_en = 1'b0; txn(8'h00, 0, 1'b0); txn(8'h01, 0, 1'b0);  // R8
    own_addr = 7'h00; txn(8'h00, 0, 1'b0);                  // R8 via compare, gc_o 0
    own_addr = 7'h5A;

    // long host delay and simultaneous commands
    txn(8'hB4, 40, 1'b0);  // R5
    txn(8'hB4, 0, 1'b1);   // R6 ack wins

    // R1: repeated START after a partial matching prefix, then a miss
    bus_start();
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1);
    bus_rstart();
    send_byte(8'h3C);
    chk("R1 rstart miss", match, 0);
    ninth(seen);
    chk("R1 rstart nack", seen, 1);
    bus_stop();

    // R1: repeated START after a partial miss, then a read match
    bus_start();
    clk_bit(1'b0); clk_bit(1'b0); clk_bit(1'b0);
    bus_rstart();
    send_byte(8'hB5);
    chk("R1 rstart match", match, 1);
    chk("R2 rw read", rw, 1);
    cmd(1'b1, 1'b0);
    ninth(seen);
    chk("R1 rstart ack", seen, 0);
    bus_stop();

    // R4: after an auto NACK, a matching byte without START is ignored
    bus_start();
    send_byte(8'h10);
    ninth(seen);
    chk("R4 first nack", seen, 1);
    send_byte(8'hB4);
    chk("R4 idle after nack", match, 0);
    chk("R4 idle no stretch", scl_low, 0);
    ninth(seen);
    chk("R4 idle no ack", seen, 1);
    bus_stop();

    // R9: STOP in mid-address
    bus_start();
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    bus_stop();
    wt(4);
    chk("R9 stop match", match, 0);
    chk("R9 stop scl", scl_low, 0);
    chk("R9 stop sda", sda_low, 0);
    txn(8'hB4, 0, 1'b0);   // R9 still works after abort

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule